// File: doc/BRIEF.md
# Reference Clock Jitter to Eye-Closure Estimator

This block is a fixed-point, time-domain model of how phase jitter on a shared reference clock becomes timing error at a serial receiver. It takes a stream of phase-jitter samples and feeds each one into two second-order PLL-shaped filters. One filter stands for the transmitter PLL and the other for the receiver PLL. An optional sample delay on one branch models the difference in path length between the two. The receiver sees only the mismatch between the branches, so the transmitter output minus the receiver output goes through a first-order high-pass stage. That stage stands for the tracking of the data recovery loop. The result is the eye-closure sample.

A running peak-magnitude register keeps the worst eye-closure seen since the last clear or reset. Software loads the eleven filter coefficients and the delay setting through a simple write port. Coefficients are signed Q2.14. Each PLL branch is a direct-form-I biquad. At a sensible operating point the coefficients give 3 dB corners of about 7 MHz and 22 MHz on the two branches, damping of at least 0.54, and a high-pass corner of 1.5 MHz. Choosing those coefficients is outside this block.

Top module: `jit_eye_est`

## Requirements
- R1: While rst_n is low and after it is released, out_y is 0, out_vld is 0 and out_peak is 0. All coefficients and the delay setting reset to 0.
- R2: Each branch filter computes y[n] = sat(floor((b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]) / 2^14)). Only samples with in_vld high advance it.
- R3: The high-pass input is sat(transmitter branch output − receiver branch output).
- R4: The high-pass stage computes y[n] = sat(floor(a·(y[n-1] + d[n] − d[n-1]) / 2^14)), where d is the branch difference.
- R5: Register 11 holds the delay length in bits [3:0] and the branch select in bit 8. A length above 8 is stored as 8. Select 0 delays the transmitter branch input and select 1 delays the receiver branch input. A delayed branch with length k gets the sample accepted k strobes earlier, or 0 if fewer than k samples have arrived since the last clear. Length 0 means no delay.
- R6: The rising edge that samples in_vld high is followed by one more edge. On that edge out_y takes the new eye-closure value and out_vld goes high for one cycle.
- R7: out_peak equals the largest |out_y| over all outputs since the last clear or reset. It takes each output into account one cycle after out_vld. The magnitude of −32768 is 32768.
- R8: A clr pulse zeroes all filter state, the delay line, out_y, out_vld and out_peak, and keeps the coefficients. A sample offered in the same cycle as clr is dropped.
- R9: Registers 0–4 hold the transmitter b0, b1, b2, a1, a2 and registers 5–9 hold the receiver's in the same order. Register 10 holds the high-pass coefficient a. A write to addresses 12–15 has no effect.
- R10: With in_vld low, out_y and all filter state hold their values and out_vld stays low.
- R11: Every saturating stage (branch outputs, difference, high-pass output) clamps to the range −32768 to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of filter state and peak |
| in_vld | input | 1 | Input sample strobe |
| in_x | input | 16 | Signed phase-jitter sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| out_vld | output | 1 | Eye-closure sample strobe |
| out_y | output | 16 | Signed eye-closure sample |
| out_peak | output | 16 | Unsigned peak magnitude of out_y |

## Verification
The assertions check on every cycle that the peak never falls except on clear and always covers the last output, that a clear empties state and outputs, and that an idle strobe freezes the filters. They also check that the delay line loads the accepted sample, that out_vld follows the internal stage strobe, and that a stored delay length never exceeds the maximum. The arithmetic itself is left to the bench scenarios: the biquad and high-pass recurrences, the saturation corners, the delayed-branch alignment, the clamped delay length and the ignored addresses. There, a step-by-step model of the equations is compared with out_y and out_peak under random coefficients and inputs.

// File: rtl/jit_pkg.sv
package jit_pkg;
  localparam int          AW           = 4;
  localparam int          COEF_PER_BQ  = 5;
  localparam int          NUM_BQ       = 2;
  localparam int          NUM_COEF     = COEF_PER_BQ * NUM_BQ + 1;
  localparam logic [AW-1:0] ADDR_HPF_A = AW'(COEF_PER_BQ * NUM_BQ);
  localparam logic [AW-1:0] ADDR_DLY   = AW'(NUM_COEF);
  localparam int          SEL_BIT      = 8;
  typedef enum logic {BR_TX = 1'b0, BR_RX = 1'b1} branch_e;
endpackage

// File: rtl/jit_sat.sv
module jit_sat #(
  parameter int IW = 20,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  localparam int HW = IW - OW + 1;

  logic [HW-1:0] head;
  assign head = din[IW-1:OW-1];

  always_comb begin
    if (head == {HW{1'b0}} || head == {HW{1'b1}}) begin
      dout = din[OW-1:0];
    end else if (din[IW-1]) begin
      dout = {1'b1, {(OW-1){1'b0}}};
    end else begin
      dout = {1'b0, {(OW-1){1'b1}}};
    end
  end
endmodule

// File: rtl/jit_biquad.sv
module jit_biquad #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic signed [CW-1:0] b0,
  input  logic signed [CW-1:0] b1,
  input  logic signed [CW-1:0] b2,
  input  logic signed [CW-1:0] a1,
  input  logic signed [CW-1:0] a2,
  output logic signed [DW-1:0] y
);
  localparam int ACC_W = DW + CW + 3;

  logic signed [DW-1:0]    x1_q, x2_q, y1_q, y2_q;
  logic signed [DW-1:0]    x1_d, x2_d, y1_d, y2_d;
  logic signed [ACC_W-1:0] acc, acc_sh;
  logic signed [DW-1:0]    y_new;

  always_comb begin
    acc = ACC_W'(b0) * ACC_W'(x)
        + ACC_W'(b1) * ACC_W'(x1_q)
        + ACC_W'(b2) * ACC_W'(x2_q)
        - ACC_W'(a1) * ACC_W'(y1_q)
        - ACC_W'(a2) * ACC_W'(y2_q);
    acc_sh = acc >>> FRAC;
  end

  jit_sat #(.IW(ACC_W), .OW(DW)) u_sat (.din(acc_sh), .dout(y_new));

  always_comb begin
    x1_d = x1_q;
    x2_d = x2_q;
    y1_d = y1_q;
    y2_d = y2_q;
    if (clr) begin
      x1_d = '0;
      x2_d = '0;
      y1_d = '0;
      y2_d = '0;
    end else if (en) begin
      x1_d = x;
      x2_d = x1_q;
      y1_d = y_new;
      y2_d = y1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else begin
      x1_q <= x1_d;
      x2_q <= x2_d;
      y1_q <= y1_d;
      y2_q <= y2_d;
    end
  end

  assign y = y1_q;

  // R10: no strobe, no movement
  a_r10_bq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(y1_q) && $stable(x1_q)));
  // R2: history advances one place per strobe
  a_r2_bq_history: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (y2_q == $past(y1_q) && x2_q == $past(x1_q)));
  // R8: clear empties the section
  a_r8_bq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (y1_q == '0 && y2_q == '0 && x1_q == '0 && x2_q == '0));
endmodule

// File: rtl/jit_delay.sv
module jit_delay #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic [LW-1:0]        len,
  output logic signed [DW-1:0] xd
);
  logic signed [DW-1:0] sr_q [DEPTH];
  logic signed [DW-1:0] sr_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      sr_d[i] = sr_q[i];
      if (clr) begin
        sr_d[i] = '0;
      end else if (en) begin
        sr_d[i] = (i == 0) ? x : sr_q[(i == 0) ? 0 : i - 1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_d[i];
    end
  end

  always_comb begin
    xd = x;
    for (int k = 1; k <= DEPTH; k++) begin
      if (len == LW'(k)) xd = sr_q[k-1];
    end
  end

  // R5: first tap captures the accepted sample
  a_r5_dly_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (sr_q[0] == $past(x)));
  // R8: clear empties the line
  a_r8_dly_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sr_q[0] == '0 && sr_q[DEPTH-1] == '0));
endmodule

// File: rtl/jit_hpf.sv
module jit_hpf #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] d,
  input  logic signed [CW-1:0] a,
  output logic signed [DW-1:0] y
);
  localparam int SW = DW + 2;
  localparam int PW = SW + CW;

  logic signed [DW-1:0] y_q, d1_q, y_d, d1_d, y_new;
  logic signed [SW-1:0] sum;
  logic signed [PW-1:0] prod, prod_sh;

  always_comb begin
    sum     = SW'(y_q) + SW'(d) - SW'(d1_q);
    prod    = PW'(sum) * PW'(a);
    prod_sh = prod >>> FRAC;
  end

  jit_sat #(.IW(PW), .OW(DW)) u_sat (.din(prod_sh), .dout(y_new));

  always_comb begin
    y_d  = y_q;
    d1_d = d1_q;
    if (clr) begin
      y_d  = '0;
      d1_d = '0;
    end else if (en) begin
      y_d  = y_new;
      d1_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q  <= '0;
      d1_q <= '0;
    end else begin
      y_q  <= y_d;
      d1_q <= d1_d;
    end
  end

  assign y = y_q;

  // R4: zero gain drives the output to zero
  a_r4_hpf_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && a == '0) |=> (y_q == '0));
  // R10: output holds between stage strobes
  a_r10_hpf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(y_q));
endmodule

// File: rtl/jit_eye_est.sv
module jit_eye_est
  import jit_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int FRAC    = 14,
  parameter int MAX_DLY = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_x,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [CW-1:0]        cfg_wdata,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_y,
  output logic [DW-1:0]        out_peak
);
  localparam int LW = $clog2(MAX_DLY + 1);

  // configuration
  logic signed [CW-1:0] coef_q [NUM_COEF];
  logic signed [CW-1:0] coef_d [NUM_COEF];
  logic [LW-1:0]        dly_len_q, dly_len_d;
  branch_e              dly_sel_q, dly_sel_d;

  always_comb begin
    for (int i = 0; i < NUM_COEF; i++) coef_d[i] = coef_q[i];
    dly_len_d = dly_len_q;
    dly_sel_d = dly_sel_q;
    if (cfg_we) begin
      for (int i = 0; i < NUM_COEF; i++) begin
        if (cfg_addr == AW'(i)) coef_d[i] = cfg_wdata;
      end
      if (cfg_addr == ADDR_DLY) begin
        dly_len_d = (cfg_wdata[LW-1:0] > LW'(MAX_DLY)) ? LW'(MAX_DLY) : cfg_wdata[LW-1:0];
        dly_sel_d = branch_e'(cfg_wdata[SEL_BIT]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_COEF; i++) coef_q[i] <= '0;
      dly_len_q <= '0;
      dly_sel_q <= BR_TX;
    end else begin
      for (int i = 0; i < NUM_COEF; i++) coef_q[i] <= coef_d[i];
      dly_len_q <= dly_len_d;
      dly_sel_q <= dly_sel_d;
    end
  end

  // path delay and branch inputs
  logic signed [DW-1:0] x_dly;
  logic signed [DW-1:0] br_in  [NUM_BQ];
  logic signed [DW-1:0] br_out [NUM_BQ];
  logic                 smp_en;

  assign smp_en = in_vld && !clr;

  jit_delay #(.DW(DW), .DEPTH(MAX_DLY), .LW(LW)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(in_vld),
    .x(in_x), .len(dly_len_q), .xd(x_dly)
  );

  assign br_in[BR_TX] = (dly_sel_q == BR_TX) ? x_dly : in_x;
  assign br_in[BR_RX] = (dly_sel_q == BR_RX) ? x_dly : in_x;

  for (genvar b = 0; b < NUM_BQ; b++) begin : g_bq
    jit_biquad #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_bq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(in_vld),
      .x(br_in[b]),
      .b0(coef_q[COEF_PER_BQ*b + 0]),
      .b1(coef_q[COEF_PER_BQ*b + 1]),
      .b2(coef_q[COEF_PER_BQ*b + 2]),
      .a1(coef_q[COEF_PER_BQ*b + 3]),
      .a2(coef_q[COEF_PER_BQ*b + 4]),
      .y(br_out[b])
    );
  end

  // mismatch and high-pass stage
  logic                 v1_q, v1_d;
  logic signed [DW:0]   diff_w;
  logic signed [DW-1:0] diff;

  assign diff_w = (DW+1)'(br_out[BR_TX]) - (DW+1)'(br_out[BR_RX]);
  jit_sat #(.IW(DW+1), .OW(DW)) u_dsat (.din(diff_w), .dout(diff));

  jit_hpf #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_hpf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(v1_q),
    .d(diff), .a(coef_q[ADDR_HPF_A]), .y(out_y)
  );

  // strobes and peak tracking
  logic          ovld_d;
  logic [DW-1:0] mag, peak_q, peak_d;

  always_comb begin
    v1_d   = smp_en;
    ovld_d = v1_q && !clr;
    mag    = out_y[DW-1] ? (~out_y + 1'b1) : out_y;
    peak_d = peak_q;
    if (clr) begin
      peak_d = '0;
    end else if (out_vld && (mag > peak_q)) begin
      peak_d = mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q    <= 1'b0;
      out_vld <= 1'b0;
      peak_q  <= '0;
    end else begin
      v1_q    <= v1_d;
      out_vld <= ovld_d;
      peak_q  <= peak_d;
    end
  end

  assign out_peak = peak_q;

  // R6: a stage strobe yields an output strobe on the next edge
  a_r6_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && !clr) |=> out_vld);
  // R6: no output strobe without a stage strobe before it
  a_r6_vld_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(v1_q));
  // R7: peak never drops except on clear
  a_r7_peak_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (peak_q >= $past(peak_q)));
  // R7: peak covers the presented output
  a_r7_peak_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !clr) |=> (peak_q >= $past(mag)));
  // R8: clear empties outputs
  a_r8_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (peak_q == '0 && !out_vld && out_y == '0));
  // R5: stored delay length stays within the line
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_DLY) |=> (dly_len_q <= LW'(MAX_DLY)));
endmodule

// File: tb/sim_jit_eye_est.sv
`timescale 1ns/1ps
module sim_jit_eye_est;
  logic               clk, rst_n, clr, in_vld, cfg_we;
  logic signed [15:0] in_x;
  logic [3:0]         cfg_addr;
  logic [15:0]        cfg_wdata;
  logic               out_vld;
  logic signed [15:0] out_y;
  logic [15:0]        out_peak;

  jit_eye_est u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_x(in_x),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_vld(out_vld), .out_y(out_y), .out_peak(out_peak)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  longint cf [0:10];
  int     dlen, dsel;
  longint hist [0:7];
  longint bx1 [0:1], bx2 [0:1], by1 [0:1], by2 [0:1];
  longint hy, hd1, pk, expy;

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mdl_clear();
    for (int i = 0; i < 8; i++) hist[i] = 0;
    for (int b = 0; b < 2; b++) begin
      bx1[b] = 0; bx2[b] = 0; by1[b] = 0; by2[b] = 0;
    end
    hy = 0; hd1 = 0; pk = 0; expy = 0;
  endtask

  task automatic mdl_step(longint x);
    longint xd, acc, d, a, m;
    longint bin [0:1];
    xd = (dlen == 0) ? x : hist[dlen-1];
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    bin[0] = (dsel == 0) ? xd : x;
    bin[1] = (dsel == 1) ? xd : x;
    for (int b = 0; b < 2; b++) begin
      acc = cf[5*b]*bin[b] + cf[5*b+1]*bx1[b] + cf[5*b+2]*bx2[b]
          - cf[5*b+3]*by1[b] - cf[5*b+4]*by2[b];
      bx2[b] = bx1[b]; bx1[b] = bin[b];
      by2[b] = by1[b]; by1[b] = sat16(acc >>> 14);
    end
    d  = sat16(by1[0] - by1[1]);
    a  = cf[10];
    hy = sat16((a * (hy + d - hd1)) >>> 14);
    hd1 = d;
    expy = hy;
    m = (hy < 0) ? -hy : hy;
    if (m > pk) pk = m;
  endtask

  task automatic wr(int addr, longint v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(v);
    if (addr < 11) cf[addr] = longint'($signed(16'(v)));
    else if (addr == 11) begin
      dlen = int'(v & 15);
      if (dlen > 8) dlen = 8;
      dsel = int'((v >> 8) & 1);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(longint x, string tag);
    @(negedge clk);
    in_vld = 1'b1; in_x = 16'(x);
    mdl_step(x);
    @(negedge clk);
    in_vld = 1'b0;
    chk("R6 out_vld before stage", longint'(out_vld), 0);
    @(negedge clk);
    chk(tag, longint'(out_y), expy);
    chk("R6 out_vld strobe", longint'(out_vld), 1);
    @(negedge clk);
    chk("R7 peak", longint'(out_peak), pk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    mdl_clear();
    @(negedge clk);
    clr = 1'b0;
    chk("R8 out_y after clear", longint'(out_y), 0);
    chk("R8 peak after clear", longint'(out_peak), 0);
    chk("R8 out_vld after clear", longint'(out_vld), 0);
  endtask

  function automatic longint rnd(int lo, int hi);
    return longint'($urandom_range(hi - lo, 0)) + lo;
  endfunction

  task automatic rnd_coefs();
    for (int i = 0; i < 10; i++) wr(i, rnd(-6000, 6000));
    wr(10, rnd(8192, 16000));
  endtask

  initial begin
    longint held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; clr = 1'b0; in_vld = 1'b0; in_x = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int i = 0; i < 11; i++) cf[i] = 0;
    dlen = 0; dsel = 0;
    mdl_clear();
    repeat (3) @(negedge clk);
    chk("R1 out_y in reset", longint'(out_y), 0);
    chk("R1 out_vld in reset", longint'(out_vld), 0);
    chk("R1 peak in reset", longint'(out_peak), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_y after reset", longint'(out_y), 0);
    push(1234, "R1 zero coefficients give zero");

    // R3: transmitter pass-through against silent receiver
    wr(0, 16384); wr(10, 16384);
    push(1000, "R3 difference");
    push(-2500, "R3 difference");
    wr(5, 8192);
    push(4000, "R3 half receiver");
    push(-700, "R3 half receiver");

    // R2 / R4: random biquad and high-pass coefficients
    do_clear();
    rnd_coefs();
    for (int n = 0; n < 40; n++) push(rnd(-4000, 4000), "R2 biquad recurrence");
    wr(10, rnd(12000, 16300));
    for (int n = 0; n < 20; n++) push(rnd(-4000, 4000), "R4 high-pass recurrence");

    // R5: delayed branch alignment, select and clamp
    do_clear();
    for (int i = 0; i < 10; i++) wr(i, (i % 5 == 0) ? 16384 : 0);
    wr(10, 16384);
    wr(11, 3);
    for (int n = 0; n < 10; n++) push(rnd(-3000, 3000), "R5 tx delay 3");
    wr(11, 256 + 5);
    for (int n = 0; n < 10; n++) push(rnd(-3000, 3000), "R5 rx delay 5");
    wr(11, 12);
    for (int n = 0; n < 12; n++) push(rnd(-3000, 3000), "R5 clamped delay 8");

    // R9: unused addresses
    wr(13, 12345); wr(15, -1); wr(12, 777);
    for (int n = 0; n < 5; n++) push(rnd(-3000, 3000), "R9 unused write ignored");

    // R11: saturation corners
    do_clear();
    wr(11, 0);
    wr(0, 32767); wr(5, -32768); wr(10, 16384);
    push(30000, "R11 positive clamp");
    chk("R11 positive clamp value", longint'(out_y), 32767);
    push(-30000, "R11 negative clamp");
    chk("R11 negative clamp value", longint'(out_y), -32768);
    chk("R7 peak of -32768", longint'(out_peak), 32768);

    // R10: idle strobe keeps everything
    do_clear();
    rnd_coefs();
    for (int n = 0; n < 6; n++) push(rnd(-4000, 4000), "R2 before idle");
    held = longint'(out_y);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk("R10 out_y held", longint'(out_y), held);
      chk("R10 out_vld low", longint'(out_vld), 0);
    end
    push(rnd(-4000, 4000), "R10 state kept across idle");

    // R8: clear with a simultaneous sample
    @(negedge clk);
    clr = 1'b1; in_vld = 1'b1; in_x = 16'sd9000;
    mdl_clear();
    @(negedge clk);
    clr = 1'b0; in_vld = 1'b0;
    @(negedge clk);
    chk("R8 sample dropped on clear", longint'(out_vld), 0);
    chk("R8 out_y zero", longint'(out_y), 0);
    push(1500, "R8 coefficients kept after clear");
    push(-800, "R8 coefficients kept after clear");

    // mixed random run
    for (int blk = 0; blk < 4; blk++) begin
      rnd_coefs();
      wr(11, rnd(0, 15) + 256 * rnd(0, 1));
      if (blk == 2) do_clear();
      for (int n = 0; n < 25; n++) push(rnd(-8000, 8000), "R2 random mix");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule